// File: doc/BRIEF.md
# Conversion Data-Ready Delay Timer

This block sequences the data-ready status of a measurement engine after a conversion start command. Once started, it counts output-sample strobes until the programmed number of samples in one computation cycle has gone by, then raises a one-cycle cycle-complete pulse and sets a sticky data-ready status bit. Software clears that bit by writing a 1 to it.

When any high-pass filter is enabled at the moment of the start command, the first computation cycle is preceded by a fixed settling interval of `SETTLE_SAMPLES` strobes (3000 by default). At 4000 output samples per second, that interval lasts 750 ms. In continuous mode, later cycles complete every N strobes with no further settling. In single mode, the sequencer halts after the first completion. A start command issued while counting restarts the whole sequence, including the settling interval when it applies.

No data flows through the block. All pins are plain control and status levels or pulses, so there is no valid/ready handshake and no back-pressure. The sample strobe is a one-cycle qualifier that arrives at the output-sample rate, and the block cannot stall it.

Top module: `drdy_delay_timer`

## Requirements
- R1: After reset, `ready_o` and `cycle_done_o` are 0, and no strobe produces a completion until a start command arrives.
- R2: With no bit of `hpf_en_i` set at start, `cycle_done_o` pulses for one clock, and `ready_o` becomes 1, in the clock after the edge that samples the N-th strobe following the start. N is `cycle_cnt_i` sampled at the start.
- R3: With any bit of `hpf_en_i` set at start, the first completion comes after `SETTLE_SAMPLES` + N strobes instead of N.
- R4: With `cont_i` = 1 at start, every completion after the first follows exactly N further strobes, with no settling interval.
- R5: With `cont_i` = 0 at start, no further completion occurs after the first one until the next start command.
- R6: `ready_o` stays 1 until `ready_clr_i` is 1 at a clock edge. If a completion and a clear occur at the same edge, the completion wins and `ready_o` stays 1.
- R7: A start command during settling or counting discards the progress made so far and restarts the sequence, including settling when a filter is enabled.
- R8: A cycle count of 0 behaves as a cycle count of 1.
- R9: A strobe that arrives in the same clock as a start command is not counted.
- R10: Changes to `cycle_cnt_i`, `hpf_en_i` and `cont_i` after a start have no effect until the next start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start command, one-clock pulse |
| cont_i | input | 1 | 1 = continuous cycles, 0 = single cycle; sampled at start |
| sample_stb_i | input | 1 | One-clock output-sample strobe |
| cycle_cnt_i | input | CNT_W | Samples per computation cycle (N); sampled at start |
| hpf_en_i | input | NUM_HPF | High-pass filter enable bits; sampled at start |
| ready_clr_i | input | 1 | Write-one clear of the data-ready bit |
| ready_o | output | 1 | Sticky data-ready status |
| cycle_done_o | output | 1 | One-clock cycle-complete pulse |

## Verification
The bench builds the block with `SETTLE_SAMPLES` = 10, `CNT_W` = 6 and `NUM_HPF` = 2. With these values, the complete settle-then-count path, a restart partway through settling and several continuous cycles can all be observed strobe by strobe within a short run. Two filter enable bits let the bench show that either bit alone triggers the settling interval. The narrow count width also puts the zero-count substitution and the settling/count boundary close to one another.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_COUNT  = 2'd2
  } phase_e;
endpackage

// File: rtl/drdy_sample_cnt.sv
module drdy_sample_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         at_limit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == limit_i);

  // the counter is cleared whenever the limit it is compared against changes,
  // so it must never run past that limit (also covers N=0 -> limit 0)
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i)
    else $error("sample counter passed its limit");
endmodule

// File: rtl/drdy_phase_ctrl.sv
module drdy_phase_ctrl
  import drdy_pkg::*;
#(
  parameter int CNT_W          = 24,
  parameter int SETTLE_SAMPLES = 3000,
  parameter int CW             = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             hpf_any_i,
  input  logic [CNT_W-1:0] cycle_cnt_i,
  input  logic             strobe_i,
  input  logic             at_limit_i,
  output logic             cnt_clear_o,
  output logic             cnt_step_o,
  output logic [CW-1:0]    limit_o,
  output logic             hit_o,
  output logic             done_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] nlim_q;
  logic             cont_q;
  logic             done_q;
  logic             settle_end;
  logic             use_settle;
  logic [CW-1:0]    settle_lim;

  // a parameter picks whether the settling phase exists at all
  generate
    if (SETTLE_SAMPLES > 0) begin : g_settle
      assign use_settle = hpf_any_i;
      assign settle_lim = CW'(SETTLE_SAMPLES - 1);
    end else begin : g_no_settle
      assign use_settle = 1'b0;
      assign settle_lim = '0;
    end
  endgenerate

  assign cnt_step_o = strobe_i && !start_i && (phase_q != PH_IDLE);
  assign hit_o      = cnt_step_o && (phase_q == PH_COUNT) && at_limit_i;
  assign settle_end = cnt_step_o && (phase_q == PH_SETTLE) && at_limit_i;
  assign cnt_clear_o = start_i || settle_end || hit_o;
  assign limit_o    = (phase_q == PH_SETTLE) ? settle_lim : CW'(nlim_q);

  always_comb begin
    phase_d = phase_q;
    if (start_i)         phase_d = use_settle ? PH_SETTLE : PH_COUNT;
    else if (settle_end) phase_d = PH_COUNT;
    else if (hit_o)      phase_d = cont_q ? PH_COUNT : PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      nlim_q  <= '0;
      cont_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= hit_o;
      if (start_i) begin
        cont_q <= cont_i;
        nlim_q <= (cycle_cnt_i == '0) ? '0 : cycle_cnt_i - 1'b1;
      end
    end
  end

  assign done_o = done_q;

  // a completion always follows a counted strobe, never a start clock
  p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(strobe_i) && !$past(start_i)))
    else $error("completion without a counted strobe");

  // single mode halts after its completion
  p_single_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cont_q) |-> (phase_q == PH_IDLE))
    else $error("single mode kept running");

  // settling always hands over to counting, never to idle
  p_settle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE) |=> (phase_q != PH_IDLE))
    else $error("settling ended without counting");

  // a start always leaves the sequencer active
  p_start_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase_q != PH_IDLE) && !done_q)
    else $error("start did not restart the sequence");
endmodule

// File: rtl/drdy_status_reg.sv
module drdy_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic ready_o
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ready_q <= 1'b0;
    else if (set_i) ready_q <= 1'b1;
    else if (clr_i) ready_q <= 1'b0;
  end

  assign ready_o = ready_q;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !clr_i) |=> ready_q)
    else $error("ready dropped without a clear");

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ready_q)
    else $error("completion did not set ready");
endmodule

// File: rtl/drdy_delay_timer.sv
module drdy_delay_timer
  import drdy_pkg::*;
#(
  parameter int CNT_W          = 24,
  parameter int NUM_HPF        = 2,
  parameter int SETTLE_SAMPLES = 3000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cont_i,
  input  logic               sample_stb_i,
  input  logic [CNT_W-1:0]   cycle_cnt_i,
  input  logic [NUM_HPF-1:0] hpf_en_i,
  input  logic               ready_clr_i,
  output logic               ready_o,
  output logic               cycle_done_o
);
  localparam int SETTLE_W = $clog2(SETTLE_SAMPLES + 1);
  localparam int CW       = (SETTLE_W > CNT_W) ? SETTLE_W : CNT_W;

  logic          hpf_any;
  logic          cnt_clear, cnt_step, at_limit, hit;
  logic [CW-1:0] limit;

  assign hpf_any = |hpf_en_i;

  drdy_phase_ctrl #(
    .CNT_W(CNT_W), .SETTLE_SAMPLES(SETTLE_SAMPLES), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .hpf_any_i(hpf_any), .cycle_cnt_i(cycle_cnt_i), .strobe_i(sample_stb_i),
    .at_limit_i(at_limit), .cnt_clear_o(cnt_clear), .cnt_step_o(cnt_step),
    .limit_o(limit), .hit_o(hit), .done_o(cycle_done_o)
  );

  drdy_sample_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(cnt_clear), .step_i(cnt_step),
    .limit_i(limit), .at_limit_o(at_limit)
  );

  drdy_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(ready_clr_i),
    .ready_o(ready_o)
  );

  // ready can only rise together with a completion pulse
  p_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> cycle_done_o)
    else $error("ready rose without completion");
endmodule

// File: tb/test_drdy_delay_timer.sv
`timescale 1ns/1ps
module test_drdy_delay_timer;
  localparam int CNT_W  = 6;
  localparam int NHPF   = 2;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cont = 1'b0, stb = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] ncyc = '0;
  logic [NHPF-1:0]  hpf = '0;
  logic ready, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  drdy_delay_timer #(.CNT_W(CNT_W), .NUM_HPF(NHPF), .SETTLE_SAMPLES(SETTLE)) i_drdy_delay_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
    .sample_stb_i(stb), .cycle_cnt_i(ncyc), .hpf_en_i(hpf),
    .ready_clr_i(clr), .ready_o(ready), .cycle_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input bit c, input logic [NHPF-1:0] h, input int n);
    @(negedge clk);
    start = 1'b1; cont = c; hpf = h; ncyc = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // feed n strobes; report index of the first completion and total completions
  task automatic feed(input int n, output int first, output int total);
    first = 0; total = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); stb = 1'b1;
      @(negedge clk); stb = 1'b0;
      if (done) begin
        total++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    int f, t;
    chk(ready == 1'b0, "R1 ready after reset", ready, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    feed(4, f, t);
    chk(t == 0, "R1 no completion before start", t, 0);
  endtask

  task automatic t_plain();
    int f, t;
    do_start(1'b0, 2'b00, 5);
    feed(5, f, t);
    chk(f == 5, "R2 first completion index", f, 5);
    chk(ready == 1'b1, "R2 ready set", ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R2 done is one clock", done, 0);
    feed(8, f, t);
    chk(t == 0, "R5 single mode halts", t, 0);
    chk(ready == 1'b1, "R6 ready sticky", ready, 1);
    do_clear();
    chk(ready == 1'b0, "R6 clear drops ready", ready, 0);
  endtask

  task automatic t_settle();
    int f, t;
    do_start(1'b0, 2'b10, 4);
    feed(SETTLE + 4, f, t);
    chk(f == SETTLE + 4, "R3 settle with filter bit 1", f, SETTLE + 4);
    do_clear();
    do_start(1'b0, 2'b01, 3);
    hpf = 2'b00; ncyc = CNT_W'(1); cont = 1'b1;
    feed(SETTLE + 8, f, t);
    chk(f == SETTLE + 3, "R10 inputs after start ignored", f, SETTLE + 3);
    chk(t == 1, "R10 mode after start ignored", t, 1);
    do_clear();
  endtask

  task automatic t_cont();
    int f, t;
    do_start(1'b1, 2'b01, 3);
    feed(SETTLE + 3, f, t);
    chk(f == SETTLE + 3, "R4 first continuous cycle settles", f, SETTLE + 3);
    for (int k = 0; k < 3; k++) begin
      feed(3, f, t);
      chk(f == 3 && t == 1, "R4 later cycles every N", f, 3);
    end
  endtask

  task automatic t_restart();
    int f, t;
    do_start(1'b0, 2'b01, 4);
    feed(8, f, t);
    chk(t == 0, "R7 no completion mid settle", t, 0);
    do_start(1'b0, 2'b01, 4);
    feed(SETTLE + 4, f, t);
    chk(f == SETTLE + 4, "R7 restart includes settle", f, SETTLE + 4);
    do_start(1'b0, 2'b00, 6);
    feed(4, f, t);
    do_start(1'b0, 2'b00, 6);
    feed(6, f, t);
    chk(f == 6, "R7 restart while counting", f, 6);
    do_clear();
  endtask

  task automatic t_zero();
    int f, t;
    do_start(1'b1, 2'b00, 0);
    feed(4, f, t);
    chk(f == 1 && t == 4, "R8 zero count acts as one", t, 4);
    do_clear();
  endtask

  task automatic t_start_strobe();
    int f, t;
    @(negedge clk);
    start = 1'b1; stb = 1'b1; cont = 1'b0; hpf = '0; ncyc = CNT_W'(2);
    @(negedge clk);
    start = 1'b0; stb = 1'b0;
    chk(done == 1'b0, "R9 no completion on start clock", done, 0);
    feed(2, f, t);
    chk(f == 2, "R9 coincident strobe not counted", f, 2);
    do_clear();
  endtask

  task automatic t_clr_set();
    int f, t;
    do_start(1'b0, 2'b00, 3);
    feed(2, f, t);
    @(negedge clk); stb = 1'b1; clr = 1'b1;
    @(negedge clk); stb = 1'b0; clr = 1'b0;
    chk(done == 1'b1, "R6 completion with clear", done, 1);
    chk(ready == 1'b1, "R6 set wins over clear", ready, 1);
    do_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_settle();
    t_cont();
    t_restart();
    t_zero();
    t_start_strobe();
    t_clr_set();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule